// File: doc/BRIEF.md
# Interrupt State Collector with Test Injection

This block gathers the interrupt sources of a peripheral into a sticky state register. Software reads the register, masks it and clears it. A hardware event pulse or a software write to a write-only test register sets state bits. Software clears them by writing ones to the state register. Each interrupt pin is driven from its state bit gated by its enable bit. Software can therefore raise any interrupt on its own and follow it through the whole path to the pin.

A second path records error conditions in a sticky error status register, which is also cleared by writing ones. The single error interrupt pin is driven only by status bits whose bit is also set in an error-enable mask. The block checks for one error condition itself: a transmit push while the transmit queue is full. It marks that push as not accepted, so the excess data is dropped, and it records the overflow in error status bit 0.

The register port is a simple one with no wait states. A write takes effect at the clock edge where the write enable is high. A read is combinational from the read address.

Top module: `intr_hub`

## Requirements
- R1: After reset, every state, enable, error-enable and error status bit is zero, every interrupt pin is low, and the error interrupt is low.
- R2: A one-cycle high pulse on a hardware event input sets the matching state bit at the next clock edge. The bit stays set after the pulse ends, until software clears it.
- R3: A write to the test register (address 2) sets each state bit whose data bit is one. With the state at zero beforehand, a read of the state register (address 0) returns the written value. The test register holds nothing and always reads as zero.
- R4: A write to the state register clears each state bit whose data bit is one and leaves the other bits unchanged.
- R5: Each interrupt pin is high exactly when its state bit and its enable bit (address 1, read/write) are both set.
- R6: If a hardware event or a test write sets a state bit in the same cycle that a state write clears it, the bit ends up set.
- R7: The error status register (address 4) latches every high error-condition input at the next edge. A write of ones to address 4 clears those bits.
- R8: The error interrupt is high exactly when some error status bit is set whose error-enable bit (address 3, read/write) is also set.
- R9: A transmit push while the queue reports full is not accepted, so the accept output is low in that cycle, and error status bit 0 is set at the next edge. A push while the queue is not full is accepted and records no error.
- R10: Reads of the unmapped addresses 5 to 7 return zero. Bit i of each register belongs to interrupt or error condition i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | REG_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | REG_W | Register read data, combinational |
| hwEvent | input | NUM_IRQ | Hardware interrupt event pulses |
| errEvent | input | NUM_ERR | External error-condition pulses |
| txPush | input | 1 | Transmit data push request |
| txFull | input | 1 | Transmit queue full indication |
| txAccept | output | 1 | Push accepted and stored by the queue |
| intrOut | output | NUM_IRQ | Interrupt pins |
| intrError | output | 1 | Error interrupt pin |

## Verification
Every pairing of enable mask and test-injected value is tried at the four-bit default size. Each pairing checks the read-back of the state register, the pin gating and a partial write-one-to-clear, which separates a faulty AND gate, a wrong mask and a clear that touches the wrong bits. Every error-condition pattern is crossed with every error-enable mask, which separates a status register that filters its inputs from an interrupt that fails to filter. Directed patterns add a set and a clear hitting the same bit, an event that is removed before it is read, pushes with the queue full and not full, and reads of the unmapped and write-only addresses.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [2:0] {
    ADDR_STATE    = 3'd0,
    ADDR_ENABLE   = 3'd1,
    ADDR_TEST     = 3'd2,
    ADDR_ERR_EN   = 3'd3,
    ADDR_ERR_STAT = 3'd4
  } regAddrE;

  // Per-cycle write strobes from control to datapath
  typedef struct packed {
    logic stateClr;
    logic enableWr;
    logic testSet;
    logic errEnWr;
    logic errClr;
  } regStrobeS;

endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int NUM_ERR = 4,
  parameter int REG_W   = 4
) (
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [2:0]         rdAddr,
  input  logic [NUM_IRQ-1:0] stateQ,
  input  logic [NUM_IRQ-1:0] enQ,
  input  logic [NUM_ERR-1:0] errEnQ,
  input  logic [NUM_ERR-1:0] errStatusQ,
  output regStrobeS          strobe,
  output logic [REG_W-1:0]   rdData
);

  always_comb begin
    strobe          = '0;
    strobe.stateClr = wrEn && (wrAddr == ADDR_STATE);
    strobe.enableWr = wrEn && (wrAddr == ADDR_ENABLE);
    strobe.testSet  = wrEn && (wrAddr == ADDR_TEST);
    strobe.errEnWr  = wrEn && (wrAddr == ADDR_ERR_EN);
    strobe.errClr   = wrEn && (wrAddr == ADDR_ERR_STAT);
  end

  // Test register and unmapped addresses read as zero
  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_STATE:    rdData[NUM_IRQ-1:0] = stateQ;
      ADDR_ENABLE:   rdData[NUM_IRQ-1:0] = enQ;
      ADDR_ERR_EN:   rdData[NUM_ERR-1:0] = errEnQ;
      ADDR_ERR_STAT: rdData[NUM_ERR-1:0] = errStatusQ;
      default:       rdData = '0;
    endcase
  end

endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeS          strobe,
  input  logic [NUM_IRQ-1:0] irqData,
  input  logic [NUM_ERR-1:0] errData,
  input  logic [NUM_IRQ-1:0] hwEvent,
  input  logic [NUM_ERR-1:0] errEvent,
  input  logic               txPush,
  input  logic               txFull,
  output logic               txAccept,
  output logic [NUM_IRQ-1:0] stateQ,
  output logic [NUM_IRQ-1:0] enQ,
  output logic [NUM_ERR-1:0] errEnQ,
  output logic [NUM_ERR-1:0] errStatusQ,
  output logic [NUM_IRQ-1:0] intrOut,
  output logic               intrError
);

  logic               overflow;
  logic [NUM_IRQ-1:0] stateSet;
  logic [NUM_IRQ-1:0] stateClrMask;
  logic [NUM_ERR-1:0] errSet;
  logic [NUM_ERR-1:0] errClrMask;

  assign overflow = txPush && txFull;
  assign txAccept = txPush && !txFull;

  assign stateSet     = hwEvent | (strobe.testSet ? irqData : '0);
  assign stateClrMask = strobe.stateClr ? irqData : '0;

  // Overflow is error condition 0
  always_comb begin
    errSet    = errEvent;
    errSet[0] = errEvent[0] | overflow;
  end
  assign errClrMask = strobe.errClr ? errData : '0;

  // Set applied after clear so a coincident event is never lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= '0;
      enQ        <= '0;
      errEnQ     <= '0;
      errStatusQ <= '0;
    end else begin
      stateQ     <= (stateQ & ~stateClrMask) | stateSet;
      errStatusQ <= (errStatusQ & ~errClrMask) | errSet;
      if (strobe.enableWr) enQ    <= irqData;
      if (strobe.errEnWr)  errEnQ <= errData;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pin
    assign intrOut[i] = stateQ[i] & enQ[i];
  end

  assign intrError = |(errStatusQ & errEnQ);

endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int NUM_ERR = 4,
  parameter int REG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [2:0]         rdAddr,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_IRQ-1:0] hwEvent,
  input  logic [NUM_ERR-1:0] errEvent,
  input  logic               txPush,
  input  logic               txFull,
  output logic               txAccept,
  output logic [NUM_IRQ-1:0] intrOut,
  output logic               intrError
);

  regStrobeS          strobe;
  logic [NUM_IRQ-1:0] stateQ;
  logic [NUM_IRQ-1:0] enQ;
  logic [NUM_ERR-1:0] errEnQ;
  logic [NUM_ERR-1:0] errStatusQ;

  intr_ctrl #(.NUM_IRQ(NUM_IRQ), .NUM_ERR(NUM_ERR), .REG_W(REG_W)) u_ctrl (
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .stateQ     (stateQ),
    .enQ        (enQ),
    .errEnQ     (errEnQ),
    .errStatusQ (errStatusQ),
    .strobe     (strobe),
    .rdData     (rdData)
  );

  intr_regs #(.NUM_IRQ(NUM_IRQ), .NUM_ERR(NUM_ERR)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .irqData    (wrData[NUM_IRQ-1:0]),
    .errData    (wrData[NUM_ERR-1:0]),
    .hwEvent    (hwEvent),
    .errEvent   (errEvent),
    .txPush     (txPush),
    .txFull     (txFull),
    .txAccept   (txAccept),
    .stateQ     (stateQ),
    .enQ        (enQ),
    .errEnQ     (errEnQ),
    .errStatusQ (errStatusQ),
    .intrOut    (intrOut),
    .intrError  (intrError)
  );

endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
  parameter int NUM_IRQ = 4,
  parameter int NUM_ERR = 4,
  parameter int REG_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [2:0]         wrAddr,
  input logic [REG_W-1:0]   wrData,
  input logic [NUM_IRQ-1:0] hwEvent,
  input logic               txPush,
  input logic               txFull,
  input logic               txAccept,
  input logic [NUM_IRQ-1:0] intrOut,
  input logic [NUM_IRQ-1:0] stateQ,
  input logic [NUM_IRQ-1:0] enQ,
  input logic [NUM_ERR-1:0] errStatusQ
);

  // R2 R6
  event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hwEvent) |=> ((stateQ & $past(hwEvent)) == $past(hwEvent)));

  // R3
  test_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd2) |=>
      ((stateQ & $past(wrData[NUM_IRQ-1:0])) == $past(wrData[NUM_IRQ-1:0])));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 3'd0) |=> ((stateQ & $past(stateQ)) == $past(stateQ)));

  // R5
  pin_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intrOut & ~enQ) == '0);

  // R9
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull) |-> !txAccept);

  // R9
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull) |=> errStatusQ[0]);

endmodule

bind intr_hub intr_hub_chk #(.NUM_IRQ(NUM_IRQ), .NUM_ERR(NUM_ERR), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .hwEvent    (hwEvent),
  .txPush     (txPush),
  .txFull     (txFull),
  .txAccept   (txAccept),
  .intrOut    (intrOut),
  .stateQ     (stateQ),
  .enQ        (enQ),
  .errStatusQ (errStatusQ)
);

// File: tb/tb_intr_hub.sv
`timescale 1ns/1ps
module tb_intr_hub;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [N-1:0] rdData;
  logic [N-1:0] hwEvent = '0;
  logic [N-1:0] errEvent = '0;
  logic         txPush = 1'b0;
  logic         txFull = 1'b0;
  logic         txAccept;
  logic [N-1:0] intrOut;
  logic         intrError;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intr_hub #(.NUM_IRQ(N), .NUM_ERR(N), .REG_W(N)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hwEvent(hwEvent), .errEvent(errEvent),
    .txPush(txPush), .txFull(txFull), .txAccept(txAccept),
    .intrOut(intrOut), .intrError(intrError)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rdAddr = a;
    #0.5;
    v = int'(rdData);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1", v, 0);
    end
    check("R1 pins", int'(intrOut), 0);
    check("R1 err", int'(intrError), 0);

    // R3 R4 R5 sweep of enable mask and injected value
    for (int en = 0; en < 16; en++) begin
      wr(3'd1, N'(en));
      rd(3'd1, v);
      check("R5 enable readback", v, en);
      for (int t = 0; t < 16; t++) begin
        wr(3'd0, '1);
        wr(3'd2, N'(t));
        rd(3'd0, v);
        check("R3 state equals test", v, t);
        rd(3'd2, v);
        check("R3 test reads zero", v, 0);
        check("R5 pin gating", int'(intrOut), t & en);
        wr(3'd0, N'(en));
        rd(3'd0, v);
        check("R4 partial clear", v, t & ~en & 15);
        check("R5 pin after clear", int'(intrOut), t & ~en & en & 15);
      end
    end

    // R2 sticky hardware event
    wr(3'd0, '1);
    @(negedge clk); hwEvent = 4'b0101;
    @(negedge clk); hwEvent = '0;
    repeat (3) @(negedge clk);
    rd(3'd0, v);
    check("R2 sticky", v, 5);

    // R6 set beats clear in the same cycle
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = '1; hwEvent = 4'b1010;
    @(negedge clk);
    wrEn = 1'b0; hwEvent = '0;
    rd(3'd0, v);
    check("R6 event wins", v, 10);
    wr(3'd0, '1);
    wr(3'd2, 4'b0011);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 4'b0011; hwEvent = 4'b0001;
    @(negedge clk);
    wrEn = 1'b0; hwEvent = '0;
    rd(3'd0, v);
    check("R6 partial", v, 1);

    // R7 R8 sweep of error pattern and error-enable mask
    for (int m = 0; m < 16; m++) begin
      wr(3'd3, N'(m));
      for (int e = 0; e < 16; e++) begin
        wr(3'd4, '1);
        @(negedge clk); errEvent = N'(e);
        @(negedge clk); errEvent = '0;
        rd(3'd4, v);
        check("R7 status latch", v, e);
        check("R8 err irq", int'(intrError), ((e & m) != 0) ? 1 : 0);
        wr(3'd4, N'(m));
        rd(3'd4, v);
        check("R7 w1c", v, e & ~m & 15);
        check("R8 err irq after clear", int'(intrError), 0);
      end
    end

    // R9 overflow drop and flag
    wr(3'd3, 4'b0001);
    wr(3'd4, '1);
    @(negedge clk); txPush = 1'b1; txFull = 1'b0;
    #0.5; check("R9 accept", int'(txAccept), 1);
    @(negedge clk); txPush = 1'b0;
    rd(3'd4, v);
    check("R9 no error", v, 0);
    txPush = 1'b1; txFull = 1'b1;
    #0.5; check("R9 drop", int'(txAccept), 0);
    @(negedge clk); txPush = 1'b0; txFull = 1'b0;
    rd(3'd4, v);
    check("R9 flag", v, 1);
    check("R9 err irq", int'(intrError), 1);

    // R10 unmapped reads
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v);
      check("R10 unmapped", v, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule